// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer of a 32-bit processor that runs each instruction over several clock cycles on one shared memory, one ALU and a set of holding registers. It watches the six-bit primary opcode from the instruction register. From that opcode it steps through a chain of control states and drives every enable and multiplexer select the datapath needs: program counter writes, memory reads and writes, instruction register capture, ALU operand and operation selects, and register file writes.

The outputs are a pure function of the current state, so every strobe is glitch-free from one clock edge to the next. Every instruction starts with a fetch state and a decode state. The decode state dispatches to a path for its instruction class, and these paths differ in length, so an instruction takes three, four or five cycles. An opcode outside the supported set sends the sequencer into a trap state. The trap state raises a flag and blocks all writes until reset.

Top module: `mcc_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch state. While `rst` is high the outputs show the fetch word. Fetch asserts `mem_rd`, `ir_we` and `pc_we` with `alu_b_sel`=01. All other outputs are 0.
- R2: Fetch is always followed by decode, whatever the opcode. Decode drives `alu_b_sel`=11 with every other output 0.
- R3: Decode dispatches on `op_code`. 000000 is a register operation. 100011 is a load. 101011 is a store. 000100 is a branch. 000010 is a jump. 001000 is add-immediate.
- R4: A load runs through five states: fetch, decode, then an address state, then a read state, then a write-back state.
  - The address state drives `alu_a_sel`=1 and `alu_b_sel`=10.
  - The read state drives `mem_rd`=1 and `addr_sel_data`=1.
  - The write-back state drives `rf_we`=1, `wb_sel_mem`=1 and `rf_dst_sel`=0.
  - After write-back the sequencer returns to fetch.
- R5: A store runs through four states: fetch, decode, the address state, then a write state. The write state drives `mem_wr`=1 and `addr_sel_data`=1. The sequencer then returns to fetch.
- R6: A register operation runs through four states: fetch, decode, an execute state, then a completion state.
  - The execute state drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10.
  - The completion state drives `rf_we`=1, `rf_dst_sel`=1 and `wb_sel_mem`=0.
- R7: A branch runs through three states: fetch, decode, then a compare state. The compare state drives `pc_we_cond`=1, `pc_src`=01, `alu_mode`=01, `alu_a_sel`=1 and `alu_b_sel`=00. The sequencer then returns to fetch.
- R8: A jump runs through three states: fetch, decode, then a state driving `pc_we`=1 and `pc_src`=10. The sequencer then returns to fetch.
- R9: Add-immediate runs through four states: fetch, decode, an execute state, then a completion state.
  - The execute state drives the same word as the load/store address state.
  - The completion state drives `rf_we`=1 with `rf_dst_sel`=0 and `wb_sel_mem`=0.
- R10: An unsupported opcode at decode enters a trap state. The trap state drives `illegal_op`=1 and 0 on every other output. It stays there for any opcode until reset.
- R11: Only the decode and address states read `op_code`. A change of opcode in any other state does not alter the path.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle. In every state, any output not named for that state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Primary opcode from the instruction register |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write if ALU result is zero |
| addr_sel_data | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register capture |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU output (0) |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 use function field |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 reg A |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination field: 1 rd, 0 rt |
| illegal_op | output | 1 | Trap flag for an unsupported opcode |

## Verification
The bench walks every instruction class and checks the full output word in each cycle. A path that is one state too long or too short shows up as a missing or extra fetch word. A dispatch entry that points to the wrong class shows up as a wrong execute word.

One directed test switches the opcode to a load code in the middle of a register operation. A sequencer that reads the opcode outside decode would then stray into the memory path. Another directed test feeds valid opcodes to a trapped sequencer. A trap that leaked would resume fetching, or would raise a write strobe.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int OP_W  = 6;
    localparam int ST_W  = 4;
    localparam int SEL_W = 2;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWR    = 4'd5,
        ST_REXE   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_IEXE   = 4'd10,
        ST_TRAP   = 4'd11,
        ST_IDONE  = 4'd12
    } mcc_state_e;

    typedef struct packed {
        logic             illegal;
        logic             pc_we;
        logic             pc_we_cond;
        logic             addr_sel_data;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             wb_sel_mem;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_mode;
        logic [SEL_W-1:0] alu_b_sel;
        logic             alu_a_sel;
        logic             rf_we;
        logic             rf_dst_sel;
    } mcc_ctl_t;

    function automatic mcc_state_e dispatch(input logic [OP_W-1:0] op);
        case (op)
            OPC_RTYPE:           return ST_REXE;
            OPC_JUMP:            return ST_JUMP;
            OPC_BEQ:             return ST_BRANCH;
            OPC_ADDI:            return ST_IEXE;
            OPC_LOAD, OPC_STORE: return ST_ADDR;
            default:             return ST_TRAP;
        endcase
    endfunction
endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
#(
    parameter mcc_state_e RESET_STATE = ST_FETCH
) (
    input  logic       clk,
    input  logic       rst,
    input  mcc_state_e nxt,
    output mcc_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= RESET_STATE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  mcc_state_e      cur,
    input  logic [OP_W-1:0] op,
    output mcc_state_e      nxt
);
    always_comb begin
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch(op);
            ST_ADDR: begin
                if (op == OPC_LOAD)       nxt = ST_MRD;
                else if (op == OPC_STORE) nxt = ST_MWR;
                else                      nxt = ST_TRAP;
            end
            ST_MRD:  nxt = ST_LDWB;
            ST_REXE: nxt = ST_RDONE;
            ST_IEXE: nxt = ST_IDONE;
            ST_TRAP: nxt = ST_TRAP;
            ST_LDWB, ST_MWR, ST_RDONE, ST_BRANCH, ST_JUMP, ST_IDONE:
                     nxt = ST_FETCH;
            default: nxt = ST_TRAP;
        endcase
    end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  mcc_state_e cur,
    output mcc_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_we     = 1'b1;
                ctl.pc_we     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: ctl.alu_b_sel = 2'b11;
            ST_ADDR, ST_IEXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_MRD: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_we      = 1'b1;
                ctl.wb_sel_mem = 1'b1;
            end
            ST_MWR: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_mode  = 2'b10;
            end
            ST_RDONE: begin
                ctl.rf_we      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_mode   = 2'b01;
                ctl.pc_src     = 2'b01;
                ctl.pc_we_cond = 1'b1;
            end
            ST_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            ST_IDONE: ctl.rf_we   = 1'b1;
            ST_TRAP:  ctl.illegal = 1'b1;
            default:  ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_code,
    output logic            pc_we,
    output logic            pc_we_cond,
    output logic            addr_sel_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_we,
    output logic            wb_sel_mem,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_mode,
    output logic [1:0]      alu_b_sel,
    output logic            alu_a_sel,
    output logic            rf_we,
    output logic            rf_dst_sel,
    output logic            illegal_op
);
    mcc_state_e cur_st;
    mcc_state_e nxt_st;
    mcc_ctl_t   ctl;

    mcc_state_reg #(.RESET_STATE(ST_FETCH)) u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    mcc_next_state u_next (
        .cur (cur_st),
        .op  (op_code),
        .nxt (nxt_st)
    );

    mcc_out_decode u_out (
        .cur (cur_st),
        .ctl (ctl)
    );

    assign illegal_op    = ctl.illegal;
    assign pc_we         = ctl.pc_we;
    assign pc_we_cond    = ctl.pc_we_cond;
    assign addr_sel_data = ctl.addr_sel_data;
    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign ir_we         = ctl.ir_we;
    assign wb_sel_mem    = ctl.wb_sel_mem;
    assign pc_src        = ctl.pc_src;
    assign alu_mode      = ctl.alu_mode;
    assign alu_b_sel     = ctl.alu_b_sel;
    assign alu_a_sel     = ctl.alu_a_sel;
    assign rf_we         = ctl.rf_we;
    assign rf_dst_sel    = ctl.rf_dst_sel;
endmodule

// File: rtl/mcc_sequencer_chk.sv
module mcc_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] op_code,
    input logic       pc_we,
    input logic       pc_we_cond,
    input logic       addr_sel_data,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_we,
    input logic       wb_sel_mem,
    input logic [1:0] pc_src,
    input logic [1:0] alu_mode,
    input logic [1:0] alu_b_sel,
    input logic       alu_a_sel,
    input logic       rf_we,
    input logic       rf_dst_sel,
    input logic       illegal_op
);
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (alu_b_sel == 2'b11 && !pc_we && !mem_rd)); // R2

    AST_RTYPE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b11 && op_code == 6'b000000) |=> (alu_mode == 2'b10)); // R3

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel_data) |=> (rf_we && wb_sel_mem && !rf_dst_sel)); // R4

    AST_STORE_RETURN: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_we); // R5

    AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |=> ir_we); // R7

    AST_JUMP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == 2'b10) |=> ir_we); // R8

    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> illegal_op); // R10

    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !(pc_we || pc_we_cond || mem_wr || rf_we || ir_we)); // R10

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R12
endmodule

bind mcc_sequencer mcc_sequencer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_code       (op_code),
    .pc_we         (pc_we),
    .pc_we_cond    (pc_we_cond),
    .addr_sel_data (addr_sel_data),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .ir_we         (ir_we),
    .wb_sel_mem    (wb_sel_mem),
    .pc_src        (pc_src),
    .alu_mode      (alu_mode),
    .alu_b_sel     (alu_b_sel),
    .alu_a_sel     (alu_a_sel),
    .rf_we         (rf_we),
    .rf_dst_sel    (rf_dst_sel),
    .illegal_op    (illegal_op)
);

// File: tb/test_mcc_sequencer.sv
module test_mcc_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op_code = 6'b0;
    logic       pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, ir_we;
    logic       wb_sel_mem, alu_a_sel, rf_we, rf_dst_sel, illegal_op;
    logic [1:0] pc_src, alu_mode, alu_b_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mcc_sequencer i_mcc_sequencer (
        .clk(clk), .rst(rst), .op_code(op_code),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .addr_sel_data(addr_sel_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we), .wb_sel_mem(wb_sel_mem),
        .pc_src(pc_src), .alu_mode(alu_mode), .alu_b_sel(alu_b_sel),
        .alu_a_sel(alu_a_sel), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel),
        .illegal_op(illegal_op)
    );

    // {illegal, pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, wb_mem,
    //  pc_src[2], alu_mode[2], alu_b_sel[2], alu_a, rf_we, rf_dst}
    localparam logic [16:0] W_FETCH = 17'b0_1_0_0_1_0_1_0_00_00_01_0_0_0;
    localparam logic [16:0] W_DEC   = 17'b0_0_0_0_0_0_0_0_00_00_11_0_0_0;
    localparam logic [16:0] W_ADDR  = 17'b0_0_0_0_0_0_0_0_00_00_10_1_0_0;
    localparam logic [16:0] W_MRD   = 17'b0_0_0_1_1_0_0_0_00_00_00_0_0_0;
    localparam logic [16:0] W_LDWB  = 17'b0_0_0_0_0_0_0_1_00_00_00_0_1_0;
    localparam logic [16:0] W_MWR   = 17'b0_0_0_1_0_1_0_0_00_00_00_0_0_0;
    localparam logic [16:0] W_REXE  = 17'b0_0_0_0_0_0_0_0_00_10_00_1_0_0;
    localparam logic [16:0] W_RDONE = 17'b0_0_0_0_0_0_0_0_00_00_00_0_1_1;
    localparam logic [16:0] W_BR    = 17'b0_0_1_0_0_0_0_0_01_01_00_1_0_0;
    localparam logic [16:0] W_JMP   = 17'b0_1_0_0_0_0_0_0_10_00_00_0_0_0;
    localparam logic [16:0] W_IDONE = 17'b0_0_0_0_0_0_0_0_00_00_00_0_1_0;
    localparam logic [16:0] W_TRAP  = 17'b1_0_0_0_0_0_0_0_00_00_00_0_0_0;

    // vector table: {opcode, path length in cycles including fetch}
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        {6'b000000, 3'd4}, {6'b100011, 3'd5}, {6'b101011, 3'd4},
        {6'b000100, 3'd3}, {6'b000010, 3'd3}, {6'b001000, 3'd4},
        {6'b100011, 3'd5}, {6'b000100, 3'd3}
    };

    function automatic logic [16:0] path_word(input logic [5:0] op, input int idx);
        if (idx == 0) return W_FETCH;
        if (idx == 1) return W_DEC;
        case (op)
            6'b000000: return (idx == 2) ? W_REXE : W_RDONE;
            6'b100011: return (idx == 2) ? W_ADDR : (idx == 3) ? W_MRD : W_LDWB;
            6'b101011: return (idx == 2) ? W_ADDR : W_MWR;
            6'b000100: return W_BR;
            6'b000010: return W_JMP;
            6'b001000: return (idx == 2) ? W_ADDR : W_IDONE;
            default:   return W_TRAP;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input int idx);
        if (idx == 0) return "R1";
        if (idx == 1) return "R2";
        case (op)
            6'b000000: return "R6";
            6'b100011: return "R4";
            6'b101011: return "R5";
            6'b000100: return "R7";
            6'b000010: return "R8";
            6'b001000: return "R9";
            default:   return "R10";
        endcase
    endfunction

    function automatic logic [16:0] actual();
        return {illegal_op, pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, ir_we,
                wb_sel_mem, pc_src, alu_mode, alu_b_sel, alu_a_sel, rf_we, rf_dst_sel};
    endfunction

    task automatic check(input logic [16:0] exp, input string req);
        n_chk++;
        if (actual() !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, actual(), exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(W_FETCH, "R1");   // reset holds the fetch word
        rst = 1'b0;
        check(W_FETCH, "R1");

        // table walk: R3 dispatch for every class
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < int'(VEC[v][2:0]); i++) begin
                op_code = VEC[v][8:3];
                check(path_word(VEC[v][8:3], i), req_of(VEC[v][8:3], i));
                if (i == 2) check(path_word(VEC[v][8:3], 2), "R3");
                step();
            end
        end
        check(W_FETCH, "R2");   // the last path returned to fetch

        // R11: change opcode during register execute
        op_code = 6'b000000;
        step(); check(W_DEC, "R2");
        step(); check(W_REXE, "R11");
        op_code = 6'b100011;
        step(); check(W_RDONE, "R11");
        step(); check(W_FETCH, "R11");

        // R2: fetch ignores an illegal opcode on its way to decode
        op_code = 6'b111111;
        step(); check(W_DEC, "R2");

        // R10: trap and hold under valid opcodes
        step(); check(W_TRAP, "R10");
        op_code = 6'b000000;
        step(); check(W_TRAP, "R10");
        op_code = 6'b100011;
        step(); check(W_TRAP, "R10");
        op_code = 6'b000010;
        repeat (3) step();
        check(W_TRAP, "R10");

        // R1: reset recovers from trap
        rst = 1'b1;
        step(); check(W_FETCH, "R1");
        rst = 1'b0;
        step(); check(W_DEC, "R1");

        // R12: store path must never overlap read and write
        op_code = 6'b101011;
        step(); check(W_ADDR, "R12");
        step(); check(W_MWR, "R12");
        step(); check(W_FETCH, "R5");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule